// File: doc/BRIEF.md
# SDRAM Bank State Tracker

This block sits beside a four-bank synchronous DRAM and watches the command pins on every clock. It decodes each command that is presented while the clock enable is high and the chip select is low. For each bank it keeps one of four states: idle, active, auto-precharging or precharging. It enforces two minimum delays in clock cycles. The first runs from activate to precharge and is set by `T_RAS`. The second runs from precharge to the next command and is set by `T_RP`. Any command that breaks the protocol raises a one-cycle violation pulse and has no effect on the tracked state.

A controller or a protocol monitor reads the per-bank state and the all-idle flag to see when a bank can take an activate, a refresh or a mode write. It reads the registered command strobes to follow the command stream. The `full_page` input tells the tracker that the programmed burst length is full page. Auto-precharge is not allowed in that case. While `cke` is low, the internal clock is treated as suspended. Nothing is decoded and all timers hold their values.

Top module: `sdram_bank_tracker`

## Requirements
- R1: With `cke` high and `cs_n` low, the pin patterns {ras_n,cas_n,we_n} decode as follows. 011 is activate (strobe bit 0). 101 is read (bit 1). 100 is write (bit 2). 010 with `a10` low is single-bank precharge (bit 3). 010 with `a10` high is precharge-all (bit 4). 001 is refresh (bit 5). 000 is mode write (bit 6). 110 is burst stop (bit 7). `cmd_strobe` shows the decoded command, one-hot, in the cycle after the sampling edge.
- R2: A cycle with `cs_n` high, or with `cs_n` low and pattern 111, gives no strobe, no violation and no state change.
- R3: A sampling edge with `cke` low decodes nothing. Bank states and timers keep their values, and cycle counts advance only on edges where `cke` is high.
- R4: An activate to an idle bank makes that bank active (state code 1). An activate to a bank that is not idle is a violation and is ignored.
- R5: A single-bank precharge to an active bank is accepted only if at least `T_RAS` enabled edges have passed since the activate. An earlier one is a violation, and the bank stays active.
- R6: A precharge accepted at edge p puts the bank in state 3 (precharging). The bank reads idle (code 0) from edge p+T_RP-1 onward, so an activate is first accepted at edge p+T_RP. A precharge to a bank that is idle or already precharging is legal and does nothing.
- R7: Precharge-all moves every active bank to precharging. If any bank is active for fewer than `T_RAS` enabled edges, or any bank is auto-precharging, the command is a violation and no bank changes.
- R8: A read or write to a bank that is not active is a violation and is ignored.
- R9: A read or write with `a10` high puts the bank in state 2 (auto-precharging). Its internal precharge happens at edge max(r+1, a+T_RAS), where r is the read or write edge and a is the activate edge. After that the bank follows the R6 timing to idle.
- R10: An activate, read, write or single precharge to an auto-precharging bank is a violation and is ignored.
- R11: A read or write with `a10` high while `full_page` is high is a violation and is ignored.
- R12: `all_idle` is high exactly when every bank reads code 0. A refresh or mode write while `all_idle` is low is a violation.
- R13: `violation` is high for exactly the one cycle after each edge that sampled an illegal command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| a10 | input | 1 | Address bit 10: auto-precharge / precharge-all qualifier |
| full_page | input | 1 | Programmed burst length is full page |
| bank_state | output | 8 | Two bits per bank: 0 idle, 1 active, 2 auto-precharging, 3 precharging |
| all_idle | output | 1 | Every bank idle |
| cmd_strobe | output | 8 | Registered one-hot decoded command |
| violation | output | 1 | One-cycle protocol violation pulse |

## Verification
If a bank's state register is wrong, the error shows on `bank_state` in the cycle right after the edge where it happened. If a tRAS or tRP down-counter is off, the state output does not move at once. The error shows later: either a precharge or activate is accepted one cycle early or late, which gives a wrong `violation` value on that command, or a precharging bank turns idle at the wrong edge. For that reason the bench sends commands exactly at each timing boundary. It also compares every output with a timestamp-based model on every clock.

// File: rtl/sbt_pkg.sv
package sbt_pkg;

  typedef enum logic [3:0] {
    C_NONE, C_ACT, C_RD, C_WR, C_PRE, C_PREALL, C_REF, C_MRS, C_BST
  } cmd_e;

  typedef enum logic [1:0] {
    B_IDLE   = 2'd0,
    B_ACTIVE = 2'd1,
    B_AUTO   = 2'd2,
    B_PRECH  = 2'd3
  } bank_st_e;

endpackage

// File: rtl/sbt_rst_sync.sv
module sbt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/sbt_cmd_decode.sv
module sbt_cmd_decode
  import sbt_pkg::*;
(
  input  logic cke,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic a10,
  output cmd_e cmd
);
  always_comb begin
    cmd = C_NONE;
    if (cke && !cs_n) begin
      unique case ({ras_n, cas_n, we_n})
        3'b011:  cmd = C_ACT;
        3'b101:  cmd = C_RD;
        3'b100:  cmd = C_WR;
        3'b010:  cmd = a10 ? C_PREALL : C_PRE;
        3'b001:  cmd = C_REF;
        3'b000:  cmd = C_MRS;
        3'b110:  cmd = C_BST;
        default: cmd = C_NONE;
      endcase
    end
  end
endmodule

// File: rtl/sbt_bank.sv
module sbt_bank
  import sbt_pkg::*;
#(
  parameter int T_RAS = 5,
  parameter int T_RP  = 3
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  cmd_e     cmd,
  input  logic     hit,
  input  logic     a10,
  input  logic     full_page,
  input  logic     pre_all_go,
  output bank_st_e state_o,
  output logic     pre_busy_o,
  output logic     illegal_o
);
  localparam int RAS_W = (T_RAS > 1) ? $clog2(T_RAS) : 1;
  localparam int RP_W  = (T_RP > 1) ? $clog2(T_RP) : 1;
  localparam logic [RAS_W-1:0] RAS_LD = (T_RAS > 0) ? RAS_W'(T_RAS - 1) : '0;
  localparam logic [RP_W-1:0]  RP_LD  = (T_RP > 0) ? RP_W'(T_RP - 1) : '0;

  bank_st_e         st_q, st_d;
  logic [RAS_W-1:0] ras_q, ras_d;
  logic [RP_W-1:0]  rp_q, rp_d;
  logic             run_q, run_d;
  logic             start_rp;

  logic is_rw, ras_met, bad_auto, act_ok, rw_ok, auto_go, pre_ok;

  assign is_rw    = (cmd == C_RD) || (cmd == C_WR);
  assign ras_met  = (ras_q == '0);
  assign bad_auto = a10 && full_page;
  assign act_ok   = hit && (cmd == C_ACT) && (st_q == B_IDLE);
  assign rw_ok    = hit && is_rw && (st_q == B_ACTIVE) && !bad_auto;
  assign auto_go  = rw_ok && a10;
  assign pre_ok   = (st_q == B_ACTIVE) && ras_met &&
                    ((hit && (cmd == C_PRE)) || pre_all_go);

  assign pre_busy_o = (st_q == B_AUTO) || ((st_q == B_ACTIVE) && !ras_met);
  assign illegal_o  = hit && (
                        ((cmd == C_ACT) && (st_q != B_IDLE)) ||
                        (is_rw && ((st_q != B_ACTIVE) || bad_auto)) ||
                        ((cmd == C_PRE) && pre_busy_o));
  assign state_o = st_q;

  always_comb begin
    st_d     = st_q;
    ras_d    = ras_q;
    rp_d     = rp_q;
    run_d    = run_q;
    start_rp = 1'b0;
    if (en) begin
      if (!ras_met) ras_d = ras_q - 1'b1;
      unique case (st_q)
        B_IDLE: if (act_ok) begin
          st_d  = B_ACTIVE;
          ras_d = RAS_LD;
        end
        B_ACTIVE: begin
          if (pre_ok) begin
            st_d     = B_PRECH;
            start_rp = 1'b1;
          end else if (auto_go) begin
            st_d = B_AUTO;
          end
        end
        B_AUTO:  if (!run_q && ras_met) start_rp = 1'b1;
        B_PRECH: ;
        default: ;
      endcase
      if (run_q && ((st_q == B_AUTO) || (st_q == B_PRECH))) begin
        if (rp_q <= RP_W'(1)) begin
          st_d  = B_IDLE;
          run_d = 1'b0;
        end else begin
          rp_d = rp_q - 1'b1;
        end
      end
      if (start_rp) begin
        if (T_RP <= 1) begin
          st_d = B_IDLE;
        end else begin
          run_d = 1'b1;
          rp_d  = RP_LD;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= B_IDLE;
      ras_q <= '0;
      rp_q  <= '0;
      run_q <= 1'b0;
    end else if (en) begin
      st_q  <= st_d;
      ras_q <= ras_d;
      rp_q  <= rp_d;
      run_q <= run_d;
    end
  end

  // R4: activate to an idle bank opens it
  p_act_opens_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && hit && cmd == C_ACT && st_q == B_IDLE) |=> (st_q == B_ACTIVE));

  // R5: no precharge while the tRAS window is open
  p_tras_guard_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == B_ACTIVE && ras_q != '0) |=> (st_q == B_ACTIVE || st_q == B_AUTO));

  // R3: suspended edge leaves the bank state unchanged
  p_suspend_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en) |=> $stable(st_q));
endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
  import sbt_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int T_RAS     = 5,
  parameter int T_RP      = 3,
  localparam int BA_W     = $clog2(NUM_BANKS),
  localparam int ST_W     = 2 * NUM_BANKS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cke,
  input  logic            cs_n,
  input  logic            ras_n,
  input  logic            cas_n,
  input  logic            we_n,
  input  logic [BA_W-1:0] ba,
  input  logic            a10,
  input  logic            full_page,
  output logic [ST_W-1:0] bank_state,
  output logic            all_idle,
  output logic [7:0]      cmd_strobe,
  output logic            violation
);
  logic     rst_s_n;
  cmd_e     cmd;
  bank_st_e st [NUM_BANKS];
  logic [NUM_BANKS-1:0] busy, bad;
  logic     pre_all_go, glob_bad;
  logic [7:0] stb_d;
  logic     viol_d;

  sbt_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n));

  sbt_cmd_decode u_dec (
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .a10(a10), .cmd(cmd)
  );

  assign pre_all_go = (cmd == C_PREALL) && (busy == '0);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    sbt_bank #(.T_RAS(T_RAS), .T_RP(T_RP)) u_bank (
      .clk(clk), .rst_n(rst_s_n), .en(cke), .cmd(cmd),
      .hit(ba == BA_W'(b)), .a10(a10), .full_page(full_page),
      .pre_all_go(pre_all_go), .state_o(st[b]),
      .pre_busy_o(busy[b]), .illegal_o(bad[b])
    );
    assign bank_state[2*b +: 2] = st[b];
  end

  always_comb begin
    all_idle = 1'b1;
    for (int b = 0; b < NUM_BANKS; b++)
      if (st[b] != B_IDLE) all_idle = 1'b0;
  end

  assign glob_bad = ((cmd == C_PREALL) && (busy != '0)) ||
                    (((cmd == C_REF) || (cmd == C_MRS)) && !all_idle);
  assign viol_d   = (bad != '0) || glob_bad;

  always_comb begin
    stb_d = '0;
    unique case (cmd)
      C_ACT:    stb_d[0] = 1'b1;
      C_RD:     stb_d[1] = 1'b1;
      C_WR:     stb_d[2] = 1'b1;
      C_PRE:    stb_d[3] = 1'b1;
      C_PREALL: stb_d[4] = 1'b1;
      C_REF:    stb_d[5] = 1'b1;
      C_MRS:    stb_d[6] = 1'b1;
      C_BST:    stb_d[7] = 1'b1;
      default:  stb_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      cmd_strobe <= '0;
      violation  <= 1'b0;
    end else begin
      cmd_strobe <= stb_d;
      violation  <= viol_d;
    end
  end

  // R1: at most one strobe per cycle
  p_strobe_onehot_r1: assert property (@(posedge clk) disable iff (!rst_s_n)
    $onehot0(cmd_strobe));

  // R2: deselected cycle produces nothing
  p_deselect_quiet_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    cs_n |=> (cmd_strobe == '0 && !violation));

  // R13: a bank-level illegal command pulses the flag next cycle
  p_bank_viol_r13: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cke && bad != '0) |=> violation);

  // R12: an accepted refresh leaves every bank idle
  p_ref_idle_r12: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cmd_strobe[5] && !violation) |-> all_idle);
endmodule

// File: tb/sdram_bank_tracker_tb.sv
module sdram_bank_tracker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int TRAS = 5;
  localparam int TRP = 3;

  localparam int K_NOP = 0, K_ACT = 1, K_RD = 2, K_WR = 3, K_PRE = 4,
                 K_PALL = 5, K_REF = 6, K_MRS = 7, K_BST = 8, K_DES = 9;

  logic clk = 1'b0;
  logic rst_n, cke, cs_n, ras_n, cas_n, we_n, a10, full_page;
  logic [1:0] ba;
  logic [7:0] bank_state, cmd_strobe;
  logic all_idle, violation;

  sdram_bank_tracker #(.NUM_BANKS(NB), .T_RAS(TRAS), .T_RP(TRP)) u_dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10), .full_page(full_page),
    .bank_state(bank_state), .all_idle(all_idle), .cmd_strobe(cmd_strobe),
    .violation(violation)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  string tag = "R2";

  // behavioural reference: modes and timestamps in enabled-edge units
  int mode [NB];
  int act_t [NB];
  int pch_t [NB];
  int ecyc = 0;
  int exp_state [NB];
  int exp_stb, exp_viol;

  function automatic int disp(int b, int e);
    if ((mode[b] == 2 || mode[b] == 3) && e >= pch_t[b] + TRP - 1) return 0;
    return mode[b];
  endfunction

  task automatic model_step(int k, int b, bit a, bit f);
    int e, cur [NB];
    bit busy;
    exp_stb = 0; exp_viol = 0;
    if (!cke) return;
    ecyc++; e = ecyc;
    for (int i = 0; i < NB; i++) begin
      cur[i] = disp(i, e - 1);
      if (cur[i] == 0) mode[i] = 0;
    end
    case (k)
      K_ACT: begin
        exp_stb = 1;
        if (cur[b] == 0) begin mode[b] = 1; act_t[b] = e; end
        else exp_viol = 1;
      end
      K_RD, K_WR: begin
        exp_stb = (k == K_RD) ? 2 : 4;
        if (cur[b] != 1 || (a && f)) exp_viol = 1;
        else if (a) begin
          mode[b] = 2;
          pch_t[b] = (e + 1 > act_t[b] + TRAS) ? e + 1 : act_t[b] + TRAS;
        end
      end
      K_PRE: begin
        exp_stb = 8;
        if (cur[b] == 2 || (cur[b] == 1 && e - act_t[b] < TRAS)) exp_viol = 1;
        else if (cur[b] == 1) begin mode[b] = 3; pch_t[b] = e; end
      end
      K_PALL: begin
        exp_stb = 16; busy = 0;
        for (int i = 0; i < NB; i++)
          if (cur[i] == 2 || (cur[i] == 1 && e - act_t[i] < TRAS)) busy = 1;
        if (busy) exp_viol = 1;
        else for (int i = 0; i < NB; i++)
          if (cur[i] == 1) begin mode[i] = 3; pch_t[i] = e; end
      end
      K_REF, K_MRS: begin
        exp_stb = (k == K_REF) ? 32 : 64;
        for (int i = 0; i < NB; i++) if (cur[i] != 0) exp_viol = 1;
      end
      K_BST: exp_stb = 128;
      default: ;
    endcase
    for (int i = 0; i < NB; i++) exp_state[i] = disp(i, e);
  endtask

  task automatic chk(int got, int expv, string req, string what);
    n_chk++;
    if (got != expv) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, expv);
    end
  endtask

  task automatic compare();
    int idle_exp = 1;
    for (int i = 0; i < NB; i++) begin
      chk(int'(bank_state[2*i +: 2]), exp_state[i], tag, $sformatf("bank%0d state", i));
      if (exp_state[i] != 0) idle_exp = 0;
    end
    chk(int'(cmd_strobe), exp_stb, "R1", "cmd_strobe");
    chk(int'(violation), exp_viol, tag, "violation (R13)");
    chk(int'(all_idle), idle_exp, "R12", "all_idle");
  endtask

  // drive pins for one edge, advance the model, sample at the next negedge
  task automatic op(int k, int b = 0, bit a = 0, bit f = 0);
    cs_n = 1'b0; ba = 2'(b); a10 = a; full_page = f;
    case (k)
      K_ACT:  {ras_n, cas_n, we_n} = 3'b011;
      K_RD:   {ras_n, cas_n, we_n} = 3'b101;
      K_WR:   {ras_n, cas_n, we_n} = 3'b100;
      K_PRE:  begin {ras_n, cas_n, we_n} = 3'b010; a10 = 1'b0; end
      K_PALL: begin {ras_n, cas_n, we_n} = 3'b010; a10 = 1'b1; end
      K_REF:  {ras_n, cas_n, we_n} = 3'b001;
      K_MRS:  {ras_n, cas_n, we_n} = 3'b000;
      K_BST:  {ras_n, cas_n, we_n} = 3'b110;
      K_DES:  begin cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b000; end
      default: {ras_n, cas_n, we_n} = 3'b111;
    endcase
    model_step((k == K_DES) ? K_NOP : k, b, a10, f);
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic nop(int n);
    for (int i = 0; i < n; i++) op(K_NOP);
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    report();
  end

  initial begin
    for (int i = 0; i < NB; i++) begin
      mode[i] = 0; act_t[i] = 0; pch_t[i] = 0; exp_state[i] = 0;
    end
    exp_stb = 0; exp_viol = 0;
    rst_n = 1'b0; cke = 1'b1; cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1;
    we_n = 1'b1; ba = '0; a10 = 1'b0; full_page = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare();                        // reset state
    rst_n = 1'b1;
    nop(4);

    tag = "R4"; op(K_ACT, 0); op(K_ACT, 0);
    tag = "R5"; op(K_PRE, 0); nop(1); op(K_PRE, 0); op(K_PRE, 0);
    tag = "R6"; op(K_ACT, 0); op(K_ACT, 0); op(K_ACT, 0); op(K_PRE, 1); nop(6);
    tag = "R2"; op(K_DES, 2); op(K_NOP, 3); op(K_DES, 1, 1);
    tag = "R7"; op(K_ACT, 1); op(K_ACT, 0); op(K_PALL); nop(4); op(K_PALL);
    op(K_PALL); op(K_PRE, 2); nop(4);
    tag = "R8"; op(K_RD, 3); op(K_WR, 3, 1);
    tag = "R9"; op(K_ACT, 2); op(K_RD, 2, 1); nop(1);
    tag = "R10"; op(K_WR, 2); op(K_ACT, 2); op(K_PRE, 2); op(K_PALL); nop(8);
    tag = "R9"; op(K_ACT, 0); nop(8); op(K_WR, 0, 1); nop(4);
    tag = "R11"; op(K_ACT, 3); op(K_WR, 3, 1, 1); op(K_RD, 3, 1, 1); op(K_WR, 3, 0, 1);
    tag = "R12"; op(K_REF); op(K_MRS); nop(4); op(K_PRE, 3); nop(3); op(K_REF); op(K_MRS);
    tag = "R3"; op(K_ACT, 1); cke = 1'b0;
    for (int i = 0; i < 6; i++) op(K_PRE, 1);
    cke = 1'b1; op(K_PRE, 1); nop(2); op(K_PRE, 1);
    cke = 1'b0; op(K_ACT, 1); nop(4); cke = 1'b1; nop(4);
    tag = "R1"; op(K_BST); op(K_ACT, 3); op(K_RD, 3); op(K_WR, 3); nop(5);
    op(K_PRE, 3); nop(3);

    tag = "R13";
    for (int i = 0; i < 4000; i++) begin
      cke = ($urandom_range(9) != 0);
      op($urandom_range(9), $urandom_range(3), 1'($urandom_range(1)),
         ($urandom_range(9) == 0));
    end
    cke = 1'b1;
    nop(10);
    report();
  end
endmodule